// File: doc/BRIEF.md
# Hsync-Locked Sample Strobe Generator

This block runs on a fast oversampling clock when the pixel clock of an incoming video source is not available. It brings the asynchronous horizontal sync input into the fast domain and finds its active-going edge. On each such edge it clears two divider counters. That gives a sample strobe for writing a line buffer, a second strobe at twice that rate for reading the buffer back, and a one-cycle line-start marker.

Every line restarts the dividers from zero. The delay from the sync edge to each pixel sample is therefore the same on every line, so samples do not drift from line to line. The write divider ratio `OVERSAMPLE` (N) must be even. The write strobe lands N/2 fast cycles after the restart, near the middle of a source pixel. Sync polarity and synchroniser depth are parameters.

Top module: `hsync_strobe_gen`

## Requirements
- R1: While `rst_n` is low, and after reset until the first active-going sync edge has been seen, `line_start`, `wr_stb` and `rd_stb` are all 0.
- R2: The input `hsync_in` is first captured by the clock edge that follows a change to the active level. `line_start` is then high for exactly one cycle, and it is visible after clock edge number SYNC_STAGES+1, counting that capturing edge as number 1.
- R3: Only the inactive-to-active transition of the sync input starts a line. Holding the active level, or returning to the inactive level, produces no `line_start` and does not disturb either strobe.
- R4: `wr_stb` is high for one cycle N/2 cycles after each `line_start` cycle. After that it is high every N cycles until the next line start.
- R5: `rd_stb` is high for one cycle floor(N/4) cycles after each `line_start` cycle, then every N/2 cycles until the next line start. For N=2 it is high on every cycle.
- R6: Each line start restarts both strobe sequences from the same phase, wherever the counters stood. This holds when the line length is not a multiple of N and when a line is shorter than N.
- R7: With `HS_ACTIVE_HIGH`=1 a 0-to-1 change on `hsync_in` is the active edge; with `HS_ACTIVE_HIGH`=0 a 1-to-0 change is the active edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Asynchronous horizontal sync from the video source |
| line_start | output | 1 | One-cycle pulse in the cycle the dividers restart |
| wr_stb | output | 1 | Line-buffer write sample strobe, period N |
| rd_stb | output | 1 | Line-buffer readout strobe, period N/2 |

## Verification
The bench builds the block with N=8, three synchroniser stages and an active-low sync. With these values the write, read and line-start phases are all distinct. The inverted-polarity path and a deeper synchroniser latency are both exercised. Lines of 5, 30, 40, 53, 61 and 67 cycles leave the counters at arbitrary positions when the next line arrives. The 5-cycle line ends before a full write period. Wide sync pulses hold the active level long enough that a retrigger on the inactive-going edge would shift every later strobe.

// File: rtl/hls_pkg.sv
package hls_pkg;

   // Counter width for a divide-by-ratio counter, never below one bit.
   function automatic int hls_cnt_width(input int ratio);
      return (ratio > 1) ? $clog2(ratio) : 1;
   endfunction

   // Raw reset level of the synchroniser: the inactive sync level.
   function automatic logic hls_idle_level(input bit active_high);
      return active_high ? 1'b0 : 1'b1;
   endfunction

endpackage

// File: rtl/hls_sync.sv
module hls_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("hls_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/hls_edge.sv
module hls_edge #(
   parameter bit ACTIVE_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic lvl,
   output logic rise
);

   logic prev;

   if (ACTIVE_HIGH) begin : g_pos
      assign lvl = raw;
   end else begin : g_neg
      assign lvl = ~raw;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= lvl;
   end

   assign rise = lvl & ~prev;

   // R3: a detected start is never followed by another one in the next cycle
   a_r3_rise_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

// File: rtl/hls_div.sv
module hls_div #(
   parameter int RATIO = 4,
   parameter int PHASE = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic stb
);
   import hls_pkg::*;

   localparam int CW = hls_cnt_width(RATIO);

   if (RATIO < 1 || PHASE < 0 || PHASE >= RATIO) begin : g_bad_cfg
      $error("hls_div: need RATIO >= 1 and 0 <= PHASE < RATIO");
   end

   if (RATIO == 1) begin : g_every
      assign stb = run;
   end else begin : g_count
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          cnt <= '0;
         else if (clr)                        cnt <= '0;
         else if (cnt == CW'(RATIO - 1))      cnt <= '0;
         else                                 cnt <= cnt + 1'b1;
      end

      assign stb = run && (cnt == CW'(PHASE));

      // R6: counter stays inside its divide range
      a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
         cnt <= CW'(RATIO - 1));
      // R4: strobes of a dividing counter are never back to back
      a_r4_stb_gap: assert property (@(posedge clk) disable iff (!rst_n)
         stb && !clr |=> !stb);
   end

endmodule

// File: rtl/hsync_strobe_gen.sv
module hsync_strobe_gen #(
   parameter int OVERSAMPLE     = 4,
   parameter int SYNC_STAGES    = 2,
   parameter bit HS_ACTIVE_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hsync_in,
   output logic line_start,
   output logic wr_stb,
   output logic rd_stb
);
   import hls_pkg::*;

   localparam int RD_RATIO = OVERSAMPLE / 2;
   localparam int WR_PHASE = OVERSAMPLE / 2;
   localparam int RD_PHASE = RD_RATIO / 2;
   localparam logic IDLE_RAW = hls_idle_level(HS_ACTIVE_HIGH);

   if (OVERSAMPLE < 2 || (OVERSAMPLE % 2) != 0) begin : g_bad_ratio
      $error("hsync_strobe_gen: OVERSAMPLE must be even and at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("hsync_strobe_gen: SYNC_STAGES must be at least 2");
   end

   logic hs_sync;
   logic hs_lvl;
   logic hs_rise;
   logic locked;
   logic ls_q;

   hls_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (IDLE_RAW)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (hsync_in),
      .q     (hs_sync)
   );

   hls_edge #(
      .ACTIVE_HIGH (HS_ACTIVE_HIGH)
   ) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (hs_sync),
      .lvl   (hs_lvl),
      .rise  (hs_rise)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ls_q   <= 1'b0;
         locked <= 1'b0;
      end else begin
         ls_q <= hs_rise;
         if (hs_rise) locked <= 1'b1;
      end
   end

   hls_div #(
      .RATIO (OVERSAMPLE),
      .PHASE (WR_PHASE)
   ) u_wr_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (hs_rise),
      .run   (locked),
      .stb   (wr_stb)
   );

   hls_div #(
      .RATIO (RD_RATIO),
      .PHASE (RD_PHASE)
   ) u_rd_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (hs_rise),
      .run   (locked),
      .stb   (rd_stb)
   );

   assign line_start = ls_q;

   // R2: line start lasts a single cycle
   a_r2_ls_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      line_start |=> !line_start);
   // R3: a line start follows an active synchronised level
   a_r3_ls_after_active: assert property (@(posedge clk) disable iff (!rst_n)
      line_start |-> $past(hs_lvl));
   // R4: the write phase is never zero, so no write strobe at line start
   a_r4_ls_not_wr: assert property (@(posedge clk) disable iff (!rst_n)
      line_start |-> !wr_stb);
   // R1: nothing is emitted before the first line start
   a_r1_quiet_until_lock: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(locked) && !line_start |-> !wr_stb && !rd_stb);

   if (OVERSAMPLE >= 4) begin : g_rd_chk
      // R5: read phase sits between write samples
      a_r5_rd_offset: assert property (@(posedge clk) disable iff (!rst_n)
         wr_stb |-> !rd_stb);
   end

endmodule

// File: tb/test_hsync_strobe_gen.sv
module test_hsync_strobe_gen;

   localparam int N   = 8;
   localparam int S   = 3;
   localparam int LAT = S + 1;
   localparam logic ACT  = 1'b0;   // R7: active-low build
   localparam logic IDLE = 1'b1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hsync_in = IDLE;
   logic line_start, wr_stb, rd_stb;

   int cyc = 0;
   int total = 0;
   int bad = 0;
   int any_seen = 0;
   int stop_cyc = 1000000;
   bit done = 1'b0;

   int q_ls[$];
   int q_wr[$];
   int q_rd[$];

   always #10 clk = ~clk;   // 50 MHz

   always @(posedge clk) cyc <= cyc + 1;

   hsync_strobe_gen #(
      .OVERSAMPLE     (N),
      .SYNC_STAGES    (S),
      .HS_ACTIVE_HIGH (1'b0)
   ) i_hsync_strobe_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .hsync_in   (hsync_in),
      .line_start (line_start),
      .wr_stb     (wr_stb),
      .rd_stb     (rd_stb)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // Monitor: pops expected strobe cycles and compares with observed ones
   task automatic watch(input logic v, ref int q[$], input string req);
      while (q.size() > 0 && q[0] < cyc) begin
         check(1'b0, {req, " missed strobe"}, -1, q[0]);
         void'(q.pop_front());
      end
      if (v) begin
         if (q.size() == 0) check(1'b0, {req, " unexpected strobe"}, cyc, -1);
         else               check(q.pop_front() == cyc, req, cyc, cyc);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && cyc < stop_cyc) begin
         watch(line_start, q_ls, "R2/R3/R7 line_start");
         watch(wr_stb,     q_wr, "R4/R6 wr_stb");
         watch(rd_stb,     q_rd, "R5/R6 rd_stb");
      end
      if (rst_n && (line_start || wr_stb || rd_stb)) any_seen++;
   end

   // Driver: one line of length len with an active pulse of width wid
   task automatic drive_line(input int len, input int wid, input bit last);
      int s0;
      s0 = cyc + LAT;
      hsync_in = ACT;
      q_ls.push_back(s0);
      for (int t = s0 + N/2; t < s0 + len; t += N) q_wr.push_back(t);
      for (int t = s0 + (N/2)/2; t < s0 + len; t += N/2) q_rd.push_back(t);
      if (last) stop_cyc = s0 + len;
      repeat (wid) @(negedge clk);
      hsync_in = IDLE;   // R3: inactive-going edge must not restart
      repeat (len - wid) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      if (cyc > 5000 && !done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
         finish_run();
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      // R1: reset state
      check(line_start == 1'b0, "R1 line_start in reset", line_start, 0);
      check(wr_stb == 1'b0,     "R1 wr_stb in reset",     wr_stb,     0);
      check(rd_stb == 1'b0,     "R1 rd_stb in reset",     rd_stb,     0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      // R1: no output before the first sync edge
      check(any_seen == 0, "R1 strobes before first edge", any_seen, 0);

      drive_line(53, 9,  1'b0);   // R6: length not a multiple of N
      drive_line(40, 12, 1'b0);
      drive_line(67, 5,  1'b0);
      drive_line(5,  2,  1'b0);   // R6: line shorter than N
      drive_line(30, 8,  1'b0);
      drive_line(61, 20, 1'b0);   // R3: long active hold
      drive_line(100, 9, 1'b1);

      while (cyc < stop_cyc + 2) @(negedge clk);
      check(q_ls.size() == 0, "R2 pending line_start", q_ls.size(), 0);
      check(q_wr.size() == 0, "R4 pending wr_stb",     q_wr.size(), 0);
      check(q_rd.size() == 0, "R5 pending rd_stb",     q_rd.size(), 0);
      finish_run();
   end

endmodule